// File: doc/BRIEF.md
# Bi-phase Infrared Frame Decoder

This block turns a bi-phase (Manchester) coded infrared receiver signal into 13-bit codes. Every bit cell is split in two halves of opposite level, and the transition in the middle of the cell carries the bit: a falling middle transition is a 1, a rising one is a 0. Between two equal bits an extra transition sits on the cell boundary. The line rests high. The first bit of every frame is always 1, so the first falling transition after rest marks the middle of that bit.

The receiver input is brought into the clock domain and watched for transitions of either polarity. A timer counts pulses of a tick enable between transitions. Each interval is classed as a half cell, a whole cell or illegal. A position flag records whether the last accepted transition was at the middle of a cell. A whole-cell interval from a middle lands on the next middle. A half-cell interval from a middle lands on a boundary. From a boundary, only a half-cell interval is legal. Middle transitions shift a bit into the code. After 13 bits the code is published together with a one-cycle strobe.

An illegal interval on a rising transition sends the decoder back to rest. An illegal interval on a falling transition starts a new frame at that transition, so the decoder can lock onto a frame that begins while it is confused.

Top module: `biphase_ir_rx`

## Requirements
- R1: While reset is high, and in the first cycle after it, `code_o` is 0 and `valid_o` is 0.
- R2: The interval between two transitions is the number of cycles with `tick_en` high from the earlier transition, inclusive, up to the later one, exclusive. An interval of 3 to 8 is a half cell, 9 to 16 is a whole cell, and any other value is illegal.
- R3: At rest, a falling transition starts a frame and records the fixed first bit 1, which ends up in `code_o[12]`. A rising transition at rest is ignored.
- R4: Bits are shifted in most significant first. A falling middle transition records 1 and a rising one records 0, so the first bit is `code_o[12]` and the last is `code_o[0]`.
- R5: After a middle transition, a half interval leads to a boundary and a whole interval leads to the next middle, which records a bit. After a boundary, only a half interval is legal, and it leads to a middle that records a bit.
- R6: An illegal interval on a rising transition returns the decoder to rest. On a falling transition it abandons the frame and restarts at that transition as a first bit. An abandoned frame never raises `valid_o`.
- R7: When the 13th bit is recorded, `code_o` takes the frame and `valid_o` is high for exactly one cycle. Both appear three clock edges after the `ir_in` transition that carried the bit.
- R8: `code_o` changes only in a cycle in which `valid_o` is high.
- R9: The trailing rising transition after a frame that ends in 1 has no effect: it produces no strobe and does not change the code.
- R10: Cycles with `tick_en` low do not advance interval timing. A frame whose halves last 12 cycles decodes normally when ticks come on every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Timebase pulse; intervals are measured in these ticks |
| ir_in | input | 1 | Asynchronous receiver output, high at rest |
| code_o | output | 13 | Last complete frame, first received bit in the MSB |
| valid_o | output | 1 | One-cycle strobe marking a new frame on `code_o` |

## Verification
A new code is due exactly three clock edges after the `ir_in` transition at the middle of the 13th cell. Two of these edges are synchronizer stages and one is the decision register. The driver changes `ir_in` between clock edges and adds up its own segment lengths, so it knows the cycle of that final transition before it drives the frame. It queues the code and the due cycle. The monitor samples between edges and compares both the value and the cycle of every strobe. A strobe with nothing queued is a failure, which covers abandoned frames and trailing transitions.

// File: rtl/birx_pkg.sv
package birx_pkg;

    localparam int unsigned DEF_CODE_BITS = 13;
    localparam int unsigned DEF_HALF_MIN  = 3;
    localparam int unsigned DEF_HALF_MAX  = 8;
    localparam int unsigned DEF_FULL_MIN  = 9;
    localparam int unsigned DEF_FULL_MAX  = 16;

    typedef enum logic [1:0] {
        IV_HALF = 2'd0,
        IV_FULL = 2'd1,
        IV_BAD  = 2'd2
    } ivl_cls_e;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_RUN  = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic hit;   // a transition was seen this cycle
        logic fall;  // the transition was high-to-low
    } edge_evt_t;

    function automatic ivl_cls_e classify(
        input int unsigned ticks,
        input int unsigned hmin,
        input int unsigned hmax,
        input int unsigned fmin,
        input int unsigned fmax
    );
        if (ticks >= hmin && ticks <= hmax)
            return IV_HALF;
        else if (ticks >= fmin && ticks <= fmax)
            return IV_FULL;
        else
            return IV_BAD;
    endfunction

endpackage

// File: rtl/birx_edge_det.sv
module birx_edge_det
    import birx_pkg::*;
#(
    parameter int unsigned STAGES   = 2,
    parameter logic        IDLE_LVL = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      din,
    output edge_evt_t evt_o
);
    // pipe[0] is the first synchronizer flop, pipe[STAGES-1] the settled
    // sample, pipe[STAGES] the settled sample of the previous cycle.
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (rst)
            pipe <= {(STAGES + 1){IDLE_LVL}};
        else
            pipe <= {pipe[STAGES-1:0], din};
    end

    always_comb begin
        evt_o.hit  = pipe[STAGES] ^ pipe[STAGES-1];
        evt_o.fall = pipe[STAGES] & ~pipe[STAGES-1];
    end

endmodule

// File: rtl/birx_ivl_timer.sv
module birx_ivl_timer #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             hit,
    output logic [CNT_W-1:0] ticks_o
);
    localparam logic [CNT_W-1:0] SAT = '1;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= SAT;
        else if (hit)
            cnt <= {{(CNT_W - 1){1'b0}}, tick_en};
        else if (tick_en && cnt != SAT)
            cnt <= cnt + 1'b1;
    end

    assign ticks_o = cnt;

    // R10: without a tick and without a transition the count holds
    a_r10_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        (!hit && !tick_en) |=> $stable(ticks_o));

    // R2: a transition restarts the measurement
    a_r2_restart_on_edge: assert property (@(posedge clk) disable iff (rst)
        hit |=> (ticks_o <= CNT_W'(1)));

endmodule

// File: rtl/birx_frame_fsm.sv
module birx_frame_fsm
    import birx_pkg::*;
#(
    parameter int unsigned NBITS    = DEF_CODE_BITS,
    parameter int unsigned HALF_MIN = DEF_HALF_MIN,
    parameter int unsigned HALF_MAX = DEF_HALF_MAX,
    parameter int unsigned FULL_MIN = DEF_FULL_MIN,
    parameter int unsigned FULL_MAX = DEF_FULL_MAX,
    parameter int unsigned CNT_W    = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  edge_evt_t        evt,
    input  logic [CNT_W-1:0] ticks,
    output logic [NBITS-1:0] code_o,
    output logic             valid_o
);
    localparam int unsigned CW = $clog2(NBITS + 1);

    typedef struct packed {
        rx_state_e        st;
        logic             mid;    // last accepted transition was mid-cell
        logic [CW-1:0]    nbits;  // bits gathered so far
        logic [NBITS-1:0] sr;     // shift register, oldest bit highest
    } ctx_t;

    ctx_t             cur, nxt;
    ivl_cls_e         cls;
    logic             rec, err, restart, valid_n;
    logic [NBITS-1:0] code_n;

    always_comb begin
        cls     = classify(32'(ticks), HALF_MIN, HALF_MAX, FULL_MIN, FULL_MAX);
        nxt     = cur;
        rec     = 1'b0;
        err     = 1'b0;
        restart = 1'b0;
        valid_n = 1'b0;
        code_n  = code_o;
        if (evt.hit) begin
            if (cur.st == RX_IDLE) begin
                restart = evt.fall;
            end else begin
                if (cur.mid) begin
                    case (cls)
                        IV_HALF: nxt.mid = 1'b0;
                        IV_FULL: rec     = 1'b1;
                        default: err     = 1'b1;
                    endcase
                end else if (cls == IV_HALF) begin
                    rec     = 1'b1;
                    nxt.mid = 1'b1;
                end else begin
                    err = 1'b1;
                end
                if (err) begin
                    if (evt.fall)
                        restart = 1'b1;
                    else
                        nxt.st = RX_IDLE;
                end
            end
            if (restart) begin
                nxt.st    = RX_RUN;
                nxt.mid   = 1'b1;
                nxt.nbits = CW'(1);
                nxt.sr    = NBITS'(1);
            end
            if (rec) begin
                nxt.sr    = {cur.sr[NBITS-2:0], evt.fall};
                nxt.nbits = cur.nbits + 1'b1;
                if (nxt.nbits == CW'(NBITS)) begin
                    code_n  = nxt.sr;
                    valid_n = 1'b1;
                    nxt.st  = RX_IDLE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.st    <= RX_IDLE;
            cur.mid   <= 1'b0;
            cur.nbits <= '0;
            cur.sr    <= '0;
            code_o    <= '0;
            valid_o   <= 1'b0;
        end else begin
            cur     <= nxt;
            code_o  <= code_n;
            valid_o <= valid_n;
        end
    end

    // R7: the strobe never lasts two cycles
    a_r7_single_strobe: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R8: the published code only moves together with the strobe
    a_r8_code_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(code_o) |-> valid_o);

    // R3: a rising transition at rest changes nothing
    a_r3_idle_rise_ignored: assert property (@(posedge clk) disable iff (rst)
        (cur.st == RX_IDLE && evt.hit && !evt.fall) |=> (cur.st == RX_IDLE && !valid_o));

    // R4: every published frame carries the fixed first bit
    a_r4_lead_bit: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> code_o[NBITS-1]);

    // R6: an illegal interval on a rising transition goes back to rest
    a_r6_rise_error_rest: assert property (@(posedge clk) disable iff (rst)
        (cur.st == RX_RUN && err && !evt.fall) |=> (cur.st == RX_IDLE));

    // R5: the bit count never passes the frame length
    a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
        cur.nbits <= CW'(NBITS));

endmodule

// File: rtl/biphase_ir_rx.sv
module biphase_ir_rx
    import birx_pkg::*;
#(
    parameter int unsigned NBITS       = DEF_CODE_BITS,
    parameter int unsigned HALF_MIN    = DEF_HALF_MIN,
    parameter int unsigned HALF_MAX    = DEF_HALF_MAX,
    parameter int unsigned FULL_MIN    = DEF_FULL_MIN,
    parameter int unsigned FULL_MAX    = DEF_FULL_MAX,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             ir_in,
    output logic [NBITS-1:0] code_o,
    output logic             valid_o
);
    localparam int unsigned CNT_W = $clog2(FULL_MAX + 2);

    edge_evt_t        evt;
    logic [CNT_W-1:0] ticks;

    birx_edge_det #(
        .STAGES   (SYNC_STAGES),
        .IDLE_LVL (1'b1)
    ) u_edge (
        .clk   (clk),
        .rst   (rst),
        .din   (ir_in),
        .evt_o (evt)
    );

    birx_ivl_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .hit     (evt.hit),
        .ticks_o (ticks)
    );

    birx_frame_fsm #(
        .NBITS    (NBITS),
        .HALF_MIN (HALF_MIN),
        .HALF_MAX (HALF_MAX),
        .FULL_MIN (FULL_MIN),
        .FULL_MAX (FULL_MAX),
        .CNT_W    (CNT_W)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .ticks   (ticks),
        .code_o  (code_o),
        .valid_o (valid_o)
    );

endmodule

// File: tb/biphase_ir_rx_tb.sv
`timescale 1ns/1ps
module biphase_ir_rx_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b1;
    logic        ir_in = 1'b1;
    logic [12:0] code;
    logic        valid;

    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    int    n_valid = 0;
    int    stab_bad = 0;
    bit    tick_alt = 1'b0;
    bit    done = 1'b0;
    logic [12:0] last_code = '0;

    int    exp_code[$];
    int    exp_cyc[$];
    string exp_tag[$];

    biphase_ir_rx u_dut (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .ir_in   (ir_in),
        .code_o  (code),
        .valid_o (valid)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // tick generator: every cycle, or every other cycle for R10
    initial begin
        forever begin
            @(negedge clk);
            tick_en = tick_alt ? ~tick_en : 1'b1;
        end
    end

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (valid) begin
                    n_valid++;
                    if (exp_code.size() == 0) begin
                        check(1'b0, "R6 unexpected strobe", int'(code), 0);
                    end else begin
                        automatic int    c  = exp_code.pop_front();
                        automatic int    cc = exp_cyc.pop_front();
                        automatic string t  = exp_tag.pop_front();
                        check(int'(code) == c, {t, " code"}, int'(code), c);
                        check(cyc == cc, "R7 strobe cycle", cyc, cc);
                    end
                end else if (code != last_code) begin
                    stab_bad++;
                end
                last_code = code;
            end
        end
    end

    // Drives one frame: halves of h cycles; transitions on cell boundaries
    // arrive 'shift' cycles early. Called and returns at a falling clock edge.
    task automatic send_frame(input logic [12:0] c, input int h, input int shift,
                              input bit expect_ok, input string tag);
        int lv[26];
        int dur[26];
        int sum;
        for (int i = 0; i < 13; i++) begin
            lv[2*i]     = int'(c[12-i]);
            lv[2*i + 1] = int'(!c[12-i]);
            dur[2*i]     = h;
            dur[2*i + 1] = h;
        end
        for (int k = 2; k < 26; k += 2) begin
            if (lv[k] != lv[k-1]) begin
                dur[k-1] -= shift;
                dur[k]   += shift;
            end
        end
        ir_in = 1'b1;
        repeat (30) @(negedge clk);
        sum = 0;
        for (int k = 0; k < 25; k++) sum += dur[k];
        if (expect_ok) begin
            exp_code.push_back(int'(c));
            exp_cyc.push_back(cyc + sum + 3);
            exp_tag.push_back(tag);
        end
        for (int k = 0; k < 26; k++) begin
            ir_in = lv[k][0];
            repeat (dur[k]) @(negedge clk);
        end
        ir_in = 1'b1;
        repeat (30) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(code == 13'h0, "R1 reset code", int'(code), 0);
        check(valid == 1'b0, "R1 reset strobe", int'(valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check(code == 13'h0 && valid == 1'b0, "R1 after reset", int'({valid, code}), 0);

        send_frame(13'h1ABC, 6, 0, 1'b1, "R3");    // fixed first bit, falling start
        send_frame(13'h1000, 6, 0, 1'b1, "R5");    // long run of zeros: boundary path
        send_frame(13'h1FFF, 6, 0, 1'b1, "R9");    // ends in 1: trailing rise
        send_frame(13'h1555, 8, 0, 1'b1, "R2");    // half 8, whole 16
        send_frame(13'h1333, 5, 2, 1'b1, "R2");    // halves 3 and 7, whole 10
        send_frame(13'h1800, 5, 3, 1'b0, "R6");    // interval 2: abandoned
        send_frame(13'h1E0F, 6, 0, 1'b1, "R6");    // resync after abandon
        tick_alt = 1'b1;
        send_frame(13'h12D4, 12, 0, 1'b1, "R10");  // ticks every other cycle
        tick_alt = 1'b0;
        send_frame(13'h1C71, 6, 0, 1'b1, "R4");

        repeat (40) @(negedge clk);
        check(exp_code.size() == 0, "R7 missing strobes", exp_code.size(), 0);
        check(n_valid == 8, "R9 strobe count", n_valid, 8);
        check(stab_bad == 0, "R8 code changed without strobe", stab_bad, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R7 watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule